// File: doc/BRIEF.md
# Five-State Mealy Machine with Moore Twin

This block is a synchronous finite-state machine that reads one serial bit per clock and steps through a fixed, irregular table of five states named A to E. Each state has one successor and one output bit for each input value. The output of this Mealy machine depends on both the present state and the present input bit.

Beside it runs an equivalent Moore machine that follows the same input stream. Its output depends only on its own present state. State D is reached with output 1 from C and with output 0 from B and E, so the Moore form has two copies of D, giving six states. The Moore output therefore repeats the Mealy output one cycle later. Both state vectors come out on ports for debug and for comparing the two forms.

Top module: `seq_fsm5`

## Requirements
- R1: While `rst` is high at a rising clock edge, both machines go to state A. After that edge `mealy_state` and `moore_state` read 0 and `moore_out` reads 0.
- R2: Mealy states are encoded A=0, B=1, C=2, D=3, E=4. On each rising edge the machine moves as follows, with `x_in`=0 and `x_in`=1: A goes to B or E, B goes to E or D, C goes to D or A, D goes to C or E, E goes to B or D.
- R3: `mealy_out` is combinational and reads 1 only in state C with `x_in`=0 or in state D with `x_in`=0. In every other state and input pair it reads 0.
- R4: Moore states are encoded A/0=0, B/0=1, C/1=2, D/0=3, D/1=4, E/0=5. The next Moore state is the Mealy successor of its underlying state, paired with the Mealy output of that move.
- R5: `moore_out` reads 1 exactly when `moore_state` is C/1 (2) or D/1 (4).
- R6: After reset, `moore_out` in each cycle equals the `mealy_out` of the previous cycle.
- R7: Both state vectors only take valid encodings: 0 to 4 for the Mealy machine and 0 to 5 for the Moore machine. Any other encoding falls back to A on the next edge.
- R8: Entering D from C gives the Moore state D/1. Entering D from B or E gives D/0. Whenever the Mealy machine is in D, the Moore machine is in one of the two D states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| x_in | input | 1 | Serial input bit, sampled every cycle |
| mealy_out | output | 1 | Mealy output for the present state and input |
| moore_out | output | 1 | Moore output, a function of the Moore state only |
| mealy_state | output | 3 | Present Mealy state encoding |
| moore_state | output | 3 | Present Moore state encoding |

## Verification
A fixed eleven-bit input walk leaves every state once on each input value, so all ten table entries are checked against an independent reference model. A mistake in any single successor or output shows up at the step where that entry is used. A directed test enters D from C, from B and from E, which separates the two Moore copies of D. A long pseudo-random stream with a reset in the middle checks the one-cycle lag between the two outputs, and shows that reset returns both machines to A from any state.

// File: rtl/seq_fsm5.sv
module seq_fsm5 (
  input  logic       clk,
  input  logic       rst,
  input  logic       x_in,
  output logic       mealy_out,
  output logic       moore_out,
  output logic [2:0] mealy_state,
  output logic [2:0] moore_state
);

  localparam logic [2:0] S_A = 3'd0, S_B = 3'd1, S_C = 3'd2, S_D = 3'd3, S_E = 3'd4;
  localparam logic [2:0] M_A0 = 3'd0, M_B0 = 3'd1, M_C1 = 3'd2, M_D0 = 3'd3, M_D1 = 3'd4, M_E0 = 3'd5;

  function automatic logic [2:0] succ(input logic [2:0] s, input logic x);
    case (s)
      S_A:     succ = x ? S_E : S_B;
      S_B:     succ = x ? S_D : S_E;
      S_C:     succ = x ? S_A : S_D;
      S_D:     succ = x ? S_E : S_C;
      S_E:     succ = x ? S_D : S_B;
      default: succ = S_A;
    endcase
  endfunction

  function automatic logic emit(input logic [2:0] s, input logic x);
    emit = !x && (s == S_C || s == S_D);
  endfunction

  function automatic logic [2:0] base_of(input logic [2:0] m);
    case (m)
      M_A0:       base_of = S_A;
      M_B0:       base_of = S_B;
      M_C1:       base_of = S_C;
      M_D0, M_D1: base_of = S_D;
      M_E0:       base_of = S_E;
      default:    base_of = 3'd7;
    endcase
  endfunction

  function automatic logic [2:0] moore_code(input logic [2:0] s, input logic o);
    case (s)
      S_B:     moore_code = M_B0;
      S_C:     moore_code = M_C1;
      S_D:     moore_code = o ? M_D1 : M_D0;
      S_E:     moore_code = M_E0;
      default: moore_code = M_A0;
    endcase
  endfunction

  logic [2:0] ml_q, mo_q, mo_base;

  assign mo_base     = base_of(mo_q);
  assign mealy_out   = emit(ml_q, x_in);
  assign moore_out   = (mo_q == M_C1) || (mo_q == M_D1);
  assign mealy_state = ml_q;
  assign moore_state = mo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ml_q <= S_A;
      mo_q <= M_A0;
    end else begin
      ml_q <= succ(ml_q, x_in);
      mo_q <= moore_code(succ(mo_base, x_in), emit(mo_base, x_in));
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (ml_q == S_A && mo_q == M_A0 && !moore_out));

  assert_c_zero_to_d_R2: assert property (@(posedge clk) disable iff (rst)
    (ml_q == S_C && !x_in) |=> ml_q == S_D);

  assert_mealy_out_state_R3: assert property (@(posedge clk) disable iff (rst)
    mealy_out |-> (!x_in && (ml_q == S_C || ml_q == S_D)));

  assert_one_cycle_lag_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> moore_out == $past(mealy_out));

  assert_valid_codes_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ml_q <= S_E && mo_q <= M_E0));

  assert_d_split_R8: assert property (@(posedge clk) disable iff (rst)
    (ml_q == S_D) |-> (mo_q == M_D0 || mo_q == M_D1));

  assert_moore_tracks_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> mo_base == ml_q);

endmodule

// File: tb/test_seq_fsm5.sv
module test_seq_fsm5;
  logic clk = 0, rst = 1, x_in = 0;
  logic mealy_out, moore_out;
  logic [2:0] mealy_state, moore_state;
  int n_pass = 0, n_tot = 0;
  logic [2:0] rs, rm;
  logic rprev;
  bit done = 0;

  seq_fsm5 i_seq_fsm5 (.clk, .rst, .x_in, .mealy_out, .moore_out, .mealy_state, .moore_state);

  always #5 clk = ~clk;

  function automatic logic [2:0] r_next(input logic [2:0] s, input logic x);
    case (s)
      0: return x ? 3'd4 : 3'd1;
      1: return x ? 3'd3 : 3'd4;
      2: return x ? 3'd0 : 3'd3;
      3: return x ? 3'd4 : 3'd2;
      4: return x ? 3'd3 : 3'd1;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic r_out(input logic [2:0] s, input logic x);
    return (s == 2 && x == 0) || (s == 3 && x == 0);
  endfunction

  function automatic logic [2:0] r_moore(input logic [2:0] s, input logic o);
    case (s)
      1: return 3'd1;
      2: return 3'd2;
      3: return o ? 3'd4 : 3'd3;
      4: return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tot++;
    if (ok) n_pass++;
    else $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
  endtask

  task automatic do_reset();
    rst = 1;
    @(posedge clk); #1;
    rst = 0;
    rs = 0; rm = 0; rprev = 0;
  endtask

  task automatic step(input logic x, input bit verbose);
    logic e;
    x_in = x; #1;
    e = r_out(rs, x);
    if (verbose || mealy_out !== e) check(mealy_out === e, "R3 mealy_out", mealy_out, e);
    rprev = e;
    rm = r_moore(r_next(rs, x), e);
    rs = r_next(rs, x);
    @(posedge clk); #1;
    if (verbose || mealy_state !== rs) check(mealy_state === rs, "R2 mealy_state", mealy_state, rs);
    if (verbose || moore_state !== rm) check(moore_state === rm, "R4 moore_state", moore_state, rm);
    if (verbose || moore_out !== rprev) check(moore_out === rprev, "R6 moore_out lag", moore_out, rprev);
    if (verbose) check(moore_out === (rm == 2 || rm == 4), "R5 moore_out of state", moore_out, rm);
  endtask

  task automatic t_reset();
    do_reset();
    check(mealy_state === 0, "R1 mealy reset", mealy_state, 0);
    check(moore_state === 0, "R1 moore reset", moore_state, 0);
    check(moore_out === 0, "R1 moore_out reset", moore_out, 0);
  endtask

  task automatic t_table_walk();
    logic [10:0] seq = 11'b11010010010;
    do_reset();
    for (int i = 0; i < 11; i++) step(seq[i], 1);
  endtask

  task automatic t_d_split();
    do_reset();
    step(0, 0); step(1, 0);
    check(moore_state === 3, "R8 D entered from B", moore_state, 3);
    step(0, 0); step(0, 0);
    check(moore_state === 4, "R8 D entered from C", moore_state, 4);
    check(moore_out === 1, "R8 D/1 output", moore_out, 1);
    step(1, 0); step(1, 0);
    check(moore_state === 3, "R8 D entered from E", moore_state, 3);
  endtask

  task automatic t_random();
    logic [15:0] lfsr = 16'hACE1;
    int errs_before;
    do_reset();
    errs_before = n_tot - n_pass;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0], 0);
      check(mealy_state <= 4 && moore_state <= 5, "R7 valid encodings", moore_state, 5);
      if (i == 1500) begin
        do_reset();
        check(mealy_state === 0 && moore_state === 0, "R1 mid-run reset", mealy_state, 0);
      end
    end
    check((n_tot - n_pass) == errs_before, "R6 random stream", n_tot - n_pass, errs_before);
  endtask

  initial begin
    t_reset();
    t_table_walk();
    t_d_split();
    t_random();
    done = 1;
    $display("%0d/%0d checks passed", n_pass, n_tot);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_tot++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_pass, n_tot);
      $finish;
    end
  end
endmodule